// File: doc/BRIEF.md
# Edge-Capture Timer with Prescaler

An 8-bit up-counting timer that measures the time between signal edges. The count clock is derived from the system oscillator clock by one of two fixed divisions (by 128 or by 8) and then a programmable prescaler dividing by 1, 2, 3 or 4. The prescaler is a one-cycle count enable, not a new clock, so the block runs in a single clock domain.

A capture source is selected between an external pin and an internal vertical-sync signal. It is synchronized, and an edge of programmable polarity copies the running count into a read-only capture register. The same edge restarts the counter and the divider chain from zero. Overflow and capture each raise their own interrupt request. Each pending flag is cleared only by its acknowledge line, never by software. The overflow request has two special cases that depend on the captured value.

Software uses a small register bus with three locations: control (read/write), count (read-only) and capture (read-only). A write to control with the clear bit set restarts the count. The clear bit is not stored.

Top module: `cap_timer`

## Requirements
- R1: After reset the control, count and capture registers read 00h and both interrupt requests are low.
- R2: Control bit 0 selects the base count clock. With 0 the counter advances once per 128 clock cycles, and with 1 once per 8 clock cycles (prescaler 1).
- R3: Control bits 7:6 hold a prescaler code n that divides the base count clock by n+1. Code 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 4.
- R4: A control write with bit 2 set zeroes the counter and restarts the divider chain on that write's clock edge. Bit 2 always reads back 0, and a control write with bit 2 clear leaves the count unchanged.
- R5: Control bit 3 selects the capture edge, 0 for rising and 1 for falling. An edge of the other polarity leaves the capture register and the capture request unchanged.
- R6: Control bit 5 selects the capture source, 0 for the pin and 1 for the vertical-sync input. Edges on the unselected input have no effect.
- R7: A capture edge that is present before clock edge A latches the count held after edge A+1 into the capture register, on edge A+2. On that same edge the counter and the divider chain restart from 00h.
- R8: The counter wraps from FFh to 00h. On a wrap the overflow request rises only when control bit 4 is 1.
- R9: A capture raises the capture request when control bit 1 is 1.
- R10: An overflow or capture acknowledge pulse drops the matching request on the next edge. Control writes do not change either request.
- R11: A capture that coincides with a wrap (captured value FFh) produces no overflow request for that wrap.
- R12: A capture of value 00h raises the overflow request at once when control bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, the only clock of the block |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 count, 2 capture, 3 reads zero |
| bus_wr | input | 1 | Write strobe; writes only address 0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| cap_pin | input | 1 | External capture input, asynchronous |
| vsync_in | input | 1 | Internal vertical-sync capture input, asynchronous |
| ovf_ack | input | 1 | Overflow request acknowledge |
| cap_ack | input | 1 | Capture request acknowledge |
| ovf_irq | output | 1 | Overflow interrupt request |
| cap_irq | output | 1 | Capture interrupt request |

## Verification
The assertions assume that each capture input holds a level for longer than the synchronizer depth. They also assume the source select changes only while both capture inputs sit at the same level, so the synchronized signal never shows an edge that the pins did not make. The stimulus holds every capture level for at least three clock cycles and switches source only with both inputs low. Acknowledges are one-cycle pulses. The wrap and capture coincidences are placed on exact edges counted from a clearing write.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;

  localparam int CT_DW = 8;
  localparam int CT_PS_W = 2;

  localparam int B_CLKSEL = 0;
  localparam int B_CAPIE  = 1;
  localparam int B_CLR    = 2;
  localparam int B_EDGE   = 3;
  localparam int B_OVFIE  = 4;
  localparam int B_SRC    = 5;
  localparam int B_PS_LO  = 6;

  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_COUNT = 2'd1,
    A_CAPT  = 2'd2,
    A_NONE  = 2'd3
  } ct_addr_e;

endpackage

// File: rtl/ct_tick_gen.sv
module ct_tick_gen #(
  parameter int SLOW_DIV = 128,
  parameter int FAST_DIV = 8,
  parameter int PS_W     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart_i,
  input  logic            fast_sel_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            cnt_en_o
);

  localparam int DIV_W = $clog2(SLOW_DIV);
  localparam logic [DIV_W-1:0] SLOW_LAST = DIV_W'(SLOW_DIV - 1);
  localparam logic [DIV_W-1:0] FAST_MASK = DIV_W'(FAST_DIV - 1);

  logic [DIV_W-1:0] div_q, div_d;
  logic [PS_W-1:0]  ps_q, ps_d;
  logic             slow_tick, fast_tick, base_tick;

  always_comb begin
    slow_tick = (div_q == SLOW_LAST);
    fast_tick = ((div_q & FAST_MASK) == FAST_MASK);
    base_tick = fast_sel_i ? fast_tick : slow_tick;
    cnt_en_o  = base_tick && (ps_q == ps_i);
  end

  always_comb begin
    div_d = div_q;
    ps_d  = ps_q;
    if (restart_i) begin
      div_d = '0;
      ps_d  = '0;
    end else begin
      div_d = slow_tick ? '0 : div_q + 1'b1;
      if (base_tick) begin
        ps_d = cnt_en_o ? '0 : ps_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ps_q  <= '0;
    end else begin
      div_q <= div_d;
      ps_q  <= ps_d;
    end
  end

  // R3: with a prescale above one, enables never come back to back
  p_ps_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en_o && ps_i != '0 && !restart_i) |=> !cnt_en_o);

  // R4: a restart leaves the next cycle without an enable
  p_restart_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> !cnt_en_o);

endmodule

// File: rtl/ct_edge_detect.sv
module ct_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sel_i,
  input  logic pin_i,
  input  logic vsync_i,
  input  logic fall_i,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;
  logic              src_raw, lvl;

  always_comb begin
    src_raw = src_sel_i ? vsync_i : pin_i;
    lvl     = sync_q[STAGES-1];
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_comb sync_d[g] = src_raw;
    end else begin : g_next
      always_comb sync_d[g] = sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= lvl;
    end
  end

  always_comb edge_o = fall_i ? (prev_q && !lvl) : (!prev_q && lvl);

  // R5: one physical edge yields exactly one capture event
  p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && $stable(fall_i)) |=> !edge_o);

endmodule

// File: rtl/ct_counter.sv
module ct_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en_i,
  input  logic         clr_i,
  input  logic         cap_evt_i,
  input  logic         ovf_ie_i,
  input  logic         cap_ie_i,
  input  logic         ack_ovf_i,
  input  logic         ack_cap_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cap_o,
  output logic         ovf_pend_o,
  output logic         cap_pend_o
);

  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d, cap_q, cap_d;
  logic         ovf_q, ovf_d, capp_q, capp_d;
  logic         wrap, ovf_set, cap_set;

  always_comb begin
    wrap    = cnt_en_i && (cnt_q == CNT_MAX);
    ovf_set = ovf_ie_i && ((wrap && !cap_evt_i && !clr_i) ||
                           (cap_evt_i && cnt_q == '0));
    cap_set = cap_ie_i && cap_evt_i;

    cnt_d = cnt_q;
    if (clr_i || cap_evt_i) cnt_d = '0;
    else if (cnt_en_i)      cnt_d = cnt_q + 1'b1;

    cap_d  = cap_evt_i ? cnt_q : cap_q;
    ovf_d  = ovf_set || (ovf_q && !ack_ovf_i);
    capp_d = cap_set || (capp_q && !ack_cap_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cap_q  <= '0;
      ovf_q  <= 1'b0;
      capp_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      cap_q  <= cap_d;
      ovf_q  <= ovf_d;
      capp_q <= capp_d;
    end
  end

  always_comb begin
    cnt_o      = cnt_q;
    cap_o      = cap_q;
    ovf_pend_o = ovf_q;
    cap_pend_o = capp_q;
  end

  // R4: clear strobe zeroes the count
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> cnt_q == '0);

  // R7: capture latches the old count and restarts
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_i |=> (cap_q == $past(cnt_q) && cnt_q == '0));

  // R11: a capture on the wrap suppresses the overflow
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt_i && cnt_en_i && cnt_q == CNT_MAX && !ovf_q) |=> !ovf_q);

  // R12: capture of zero raises overflow immediately
  p_early_ovf_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt_i && cnt_q == '0 && ovf_ie_i) |=> ovf_q);

  // R10: acknowledge drops the overflow request when nothing sets it
  p_ack_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ovf_i && !cnt_en_i && !cap_evt_i) |=> !ovf_q);

  // R10: acknowledge drops the capture request when no capture coincides
  p_ack_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_cap_i && !cap_evt_i) |=> !capp_q);

endmodule

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CNT_W       = 8,
  parameter int SLOW_DIV    = 128,
  parameter int FAST_DIV    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       cap_pin,
  input  logic       vsync_in,
  input  logic       ovf_ack,
  input  logic       cap_ack,
  output logic       ovf_irq,
  output logic       cap_irq
);

  import cap_timer_pkg::*;

  logic [1:0]       rst_pipe_q;
  logic             rst_int_n;
  logic [CT_DW-1:0] ctrl_q, ctrl_d;
  logic             ctrl_wr, clr_pulse, cap_evt, cnt_en;
  logic [CNT_W-1:0] cnt_w, cap_w;
  logic             ovf_pend, cap_pend;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  always_comb rst_int_n = rst_pipe_q[1];

  always_comb begin
    ctrl_wr   = bus_wr && (bus_addr == A_CTRL);
    clr_pulse = ctrl_wr && bus_wdata[B_CLR];
    ctrl_d    = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d        = bus_wdata;
      ctrl_d[B_CLR] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  ct_tick_gen #(
    .SLOW_DIV (SLOW_DIV),
    .FAST_DIV (FAST_DIV),
    .PS_W     (CT_PS_W)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .restart_i  (clr_pulse || cap_evt),
    .fast_sel_i (ctrl_q[B_CLKSEL]),
    .ps_i       (ctrl_q[B_PS_LO +: CT_PS_W]),
    .cnt_en_o   (cnt_en)
  );

  ct_edge_detect #(
    .STAGES (SYNC_STAGES)
  ) u_edge (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .src_sel_i (ctrl_q[B_SRC]),
    .pin_i     (cap_pin),
    .vsync_i   (vsync_in),
    .fall_i    (ctrl_q[B_EDGE]),
    .edge_o    (cap_evt)
  );

  ct_counter #(
    .W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cnt_en_i   (cnt_en),
    .clr_i      (clr_pulse),
    .cap_evt_i  (cap_evt),
    .ovf_ie_i   (ctrl_q[B_OVFIE]),
    .cap_ie_i   (ctrl_q[B_CAPIE]),
    .ack_ovf_i  (ovf_ack),
    .ack_cap_i  (cap_ack),
    .cnt_o      (cnt_w),
    .cap_o      (cap_w),
    .ovf_pend_o (ovf_pend),
    .cap_pend_o (cap_pend)
  );

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_COUNT: bus_rdata = CT_DW'(cnt_w);
      A_CAPT:  bus_rdata = CT_DW'(cap_w);
      default: bus_rdata = '0;
    endcase
    ovf_irq = ovf_pend;
    cap_irq = cap_pend;
  end

  // R9: a new capture request needs the enable from the cycle before
  p_cap_irq_enable_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(cap_irq) |-> $past(ctrl_q[B_CAPIE]));

  // R8: a new overflow request needs the overflow enable
  p_ovf_irq_enable_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ovf_irq) |-> $past(ctrl_q[B_OVFIE]));

endmodule

// File: tb/cap_timer_tb.sv
`timescale 1ns/1ps
module cap_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cap_pin, vsync_in, ovf_ack, cap_ack;
  logic       ovf_irq, cap_irq;

  always #2.5 clk = ~clk;

  cap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
    .vsync_in(vsync_in), .ovf_ack(ovf_ack), .cap_ack(cap_ack),
    .ovf_irq(ovf_irq), .cap_irq(cap_irq)
  );

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sb_q[$];
  event  sb_ev;
  int    checks = 0;
  int    fails  = 0;
  bit    done   = 1'b0;

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(sb_ev);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = (it.kind == 0) ? bus_rdata : {6'b0, cap_irq, ovf_irq};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic exp_reg(input logic [1:0] a, input logic [7:0] e, input string r);
    @(negedge clk);
    bus_addr = a;
    sb_q.push_back('{0, e, r});
    -> sb_ev;
  endtask

  task automatic exp_irq(input logic [1:0] e, input string r);
    @(negedge clk);
    sb_q.push_back('{1, {6'b0, e}, r});
    -> sb_ev;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk);
    cap_pin = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic set_vsync(input logic v);
    @(negedge clk);
    vsync_in = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic ack(input logic o, input logic c);
    @(negedge clk);
    ovf_ack = o; cap_ack = c;
    @(posedge clk);
    #1 begin ovf_ack = 1'b0; cap_ack = 1'b0; end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_wdata = 8'h00;
    cap_pin = 1'b0; vsync_in = 1'b0; ovf_ack = 1'b0; cap_ack = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    exp_reg(2'd0, 8'h00, "R1 ctrl");
    exp_reg(2'd1, 8'h00, "R1 count");
    exp_reg(2'd2, 8'h00, "R1 capture");
    exp_irq(2'b00, "R1 irq");

    // R2 fast base clock: one step per 8 cycles
    wr(8'h05); step(39);
    exp_reg(2'd1, 8'd4, "R2 fast before step");
    exp_reg(2'd1, 8'd5, "R2 fast on step");
    // R2 slow base clock: one step per 128 cycles
    wr(8'h04); step(255);
    exp_reg(2'd1, 8'd1, "R2 slow before step");
    exp_reg(2'd1, 8'd2, "R2 slow on step");

    // R3 prescaler codes
    wr(8'h85); step(23);
    exp_reg(2'd1, 8'd0, "R3 div3 before");
    exp_reg(2'd1, 8'd1, "R3 div3 on");
    wr(8'hC5); step(64);
    exp_reg(2'd1, 8'd2, "R3 div4");
    wr(8'h45); step(48);
    exp_reg(2'd1, 8'd3, "R3 div2");

    // R4 clear bit
    wr(8'h05); step(20);
    wr(8'h01);
    exp_reg(2'd1, 8'd2, "R4 write without clear keeps count");
    exp_reg(2'd0, 8'h01, "R4 ctrl readback");
    wr(8'h05);
    exp_reg(2'd1, 8'd0, "R4 clear zeroes count");
    exp_reg(2'd0, 8'h01, "R4 clear bit reads zero");

    // R8 wrap with overflow disabled, then enabled
    wr(8'h05); step(2048);
    exp_irq(2'b00, "R8 disabled no request");
    wr(8'h15); step(2047);
    exp_irq(2'b00, "R8 before wrap");
    exp_irq(2'b01, "R8 on wrap");
    exp_reg(2'd1, 8'd0, "R8 count wrapped");
    wr(8'h11);
    exp_irq(2'b01, "R10 ctrl write keeps request");
    ack(1'b1, 1'b0);
    exp_irq(2'b00, "R10 overflow ack");

    // R7 and R9 rising capture on the pin
    wr(8'h07); step(40);
    set_pin(1'b1);
    exp_reg(2'd2, 8'd5, "R7 captured value");
    exp_irq(2'b10, "R9 capture request");
    step(15);
    exp_reg(2'd1, 8'd2, "R7 counter restarted");
    ack(1'b0, 1'b1);
    exp_irq(2'b00, "R10 capture ack");

    // R5 polarity
    set_pin(1'b0);
    exp_reg(2'd2, 8'd5, "R5 falling ignored in rising mode");
    exp_irq(2'b00, "R5 no request on wrong edge");
    wr(8'h0F); step(16);
    set_pin(1'b1);
    exp_irq(2'b00, "R5 rising ignored in falling mode");
    set_pin(1'b0);
    exp_reg(2'd2, 8'd2, "R5 falling capture value");
    exp_irq(2'b10, "R5 falling capture request");
    ack(1'b0, 1'b1);

    // R6 source select
    wr(8'h27); step(30);
    set_pin(1'b1);
    exp_irq(2'b00, "R6 pin ignored with sync source");
    exp_reg(2'd2, 8'd2, "R6 capture unchanged");
    set_pin(1'b0);
    set_vsync(1'b1);
    exp_reg(2'd2, 8'd5, "R6 sync capture value");
    exp_irq(2'b10, "R6 sync capture request");
    ack(1'b0, 1'b1);
    set_vsync(1'b0);

    // R11 capture on the wrap edge
    wr(8'h17); step(2045);
    set_pin(1'b1);
    exp_reg(2'd2, 8'hFF, "R11 captured FF");
    exp_irq(2'b10, "R11 no overflow");
    ack(1'b1, 1'b1);
    set_pin(1'b0);

    // R12 capture of zero
    wr(8'h17); step(2);
    set_pin(1'b1);
    exp_reg(2'd2, 8'h00, "R12 captured 00");
    exp_irq(2'b11, "R12 early overflow");

    @(negedge clk);
    #2;
    done = 1'b1;
    report();
  end

endmodule